// File: doc/BRIEF.md
# Floating-Point Compare to Condition Flags

This unit compares two IEEE-754 operands and turns the relation between them into a 4-bit processor condition-flag nibble, ordered N, Z, C, V from bit 3 down to bit 0. A per-operation format code selects half, single or double precision. Operands of every format arrive right-aligned on 64-bit buses. A mode bit chooses a quiet or a signalling comparison, and an invalid-operation flag is produced next to the flags.

The relation is encoded straight into the flag pattern a branch or conditional-select stage consumes. Less, equal, greater and unordered each have their own nibble. The unordered case has a dedicated pattern, so a later condition test can tell a NaN comparison apart from an ordered one.

Results are captured on the clock edge on which the input strobe is high. They stay in place until the next strobe. Denormal flushing, rounding and trap handling belong to neighbouring logic and are not part of this unit.

Top module: `fp_cmp_nzcv`

## Requirements
- R1: When the operands are ordered and equal, `nzcv` is 4'b0110.
- R2: When operand A is less than operand B, `nzcv` is 4'b1000.
- R3: When operand A is greater than operand B, `nzcv` is 4'b0010.
- R4: When either operand is a NaN, `nzcv` is 4'b0011. A NaN is an all-ones exponent with a nonzero fraction.
- R5: `fmt` selects the format. 2'b00 is half (sign bit 15, exponent bits 14:10). 2'b01 is single (sign bit 31, exponent bits 30:23). 2'b10 and 2'b11 are double (sign bit 63, exponent bits 62:52). Bus bits above the selected width are ignored.
- R6: Positive zero and negative zero compare equal.
- R7: Non-NaN values are ordered by sign and magnitude. Between two negative operands, the one with the larger magnitude is the lesser.
- R8: Infinities order as the extremes, and two infinities of the same sign compare equal.
- R9: With `signal_cmp` = 0 (quiet), `invalid` is 1 only when an operand is a signalling NaN. A signalling NaN is a NaN whose fraction MSB is 0.
- R10: With `signal_cmp` = 1 (signalling), `invalid` is 1 when any operand is a NaN.
- R11: `nzcv` and `invalid` take their new values on the rising edge where `in_valid` is 1. They do not change on any edge where `in_valid` is 0.
- R12: While `rst_n` is low, `nzcv` is 4'b0000 and `invalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: capture a comparison on this edge |
| fmt | input | 2 | Operand format code |
| signal_cmp | input | 1 | 1 = signalling compare, 0 = quiet compare |
| op_a | input | 64 | Operand A, right-aligned |
| op_b | input | 64 | Operand B, right-aligned |
| nzcv | output | 4 | Condition flags {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag for the captured comparison |

## Verification
Any wrong decode or ordering decision in the unit appears at the ports as a wrong flag nibble. The error is visible on the first clock edge after the strobe that caused it. A misplaced field boundary, such as the wrong sign or exponent bit for a format, shows up on the next strobe in that format, either as an ordering error or as an ignored upper bit that changes the result. A capture that fires without a strobe shows up as flags changing while the strobe is low. A NaN classified the wrong way shows up as a mismatch between `invalid` and the unordered pattern.

// File: rtl/fp_cmp_nzcv.sv
module fp_cmp_nzcv #(
  parameter int BUS_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       fmt,
  input  logic             signal_cmp,
  input  logic [BUS_W-1:0] op_a,
  input  logic [BUS_W-1:0] op_b,
  output logic [3:0]       nzcv,
  output logic             invalid
);
  localparam int MAG_W = BUS_W - 1;
  localparam int DEC_W = MAG_W + 3;

  localparam logic [3:0] FL_EQ = 4'b0110;
  localparam logic [3:0] FL_LT = 4'b1000;
  localparam logic [3:0] FL_GT = 4'b0010;
  localparam logic [3:0] FL_UN = 4'b0011;

  // returns {sign, is_nan, is_snan, magnitude}
  function automatic logic [DEC_W-1:0] classify(input logic [BUS_W-1:0] x, input logic [1:0] f);
    logic s, ones, nz, top;
    logic [MAG_W-1:0] m;
    case (f)
      2'b00: begin
        s = x[15]; ones = &x[14:10]; nz = |x[9:0]; top = x[9];
        m = {{(MAG_W-15){1'b0}}, x[14:0]};
      end
      2'b01: begin
        s = x[31]; ones = &x[30:23]; nz = |x[22:0]; top = x[22];
        m = {{(MAG_W-31){1'b0}}, x[30:0]};
      end
      default: begin
        s = x[63]; ones = &x[62:52]; nz = |x[51:0]; top = x[51];
        m = x[MAG_W-1:0];
      end
    endcase
    return {s, ones & nz, ones & nz & ~top, m};
  endfunction

  logic [DEC_W-1:0] da, db;
  logic             sa, sb, na, nb, sna, snb;
  logic [MAG_W-1:0] ma, mb;
  logic             unord, both_zero, is_eq, is_lt, inv_nxt;
  logic [3:0]       flags_nxt;

  assign da = classify(op_a, fmt);
  assign db = classify(op_b, fmt);
  assign {sa, na, sna, ma} = da;
  assign {sb, nb, snb, mb} = db;

  assign unord     = na | nb;
  assign both_zero = (ma == '0) && (mb == '0);
  assign is_eq     = both_zero || ((sa == sb) && (ma == mb));
  assign is_lt     = (sa != sb) ? sa : (sa ? (ma > mb) : (ma < mb));
  assign inv_nxt   = signal_cmp ? unord : (sna | snb);

  always_comb begin
    if (unord)      flags_nxt = FL_UN;
    else if (is_eq) flags_nxt = FL_EQ;
    else if (is_lt) flags_nxt = FL_LT;
    else            flags_nxt = FL_GT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv    <= 4'b0000;
      invalid <= 1'b0;
    end else if (in_valid) begin
      nzcv    <= flags_nxt;
      invalid <= inv_nxt;
    end
  end
endmodule

module fp_cmp_nzcv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       signal_cmp,
  input logic [3:0] nzcv,
  input logic       invalid
);
  // R1 R2 R3 R4: only the four relation patterns (or the reset value) appear
  p_legal_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nzcv inside {4'b0000, 4'b0110, 4'b1000, 4'b0010, 4'b0011});

  p_invalid_unord_r4: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (nzcv == 4'b0011));

  p_sig_any_nan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signal_cmp) |=> (invalid == (nzcv == 4'b0011)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(nzcv) && $stable(invalid)));

  p_reset_r12: assert property (@(posedge clk)
    !rst_n |-> (nzcv == 4'b0000 && !invalid));
endmodule

bind fp_cmp_nzcv fp_cmp_nzcv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .signal_cmp(signal_cmp),
  .nzcv(nzcv), .invalid(invalid)
);

// File: tb/sim_fp_cmp_nzcv.sv
module sim_fp_cmp_nzcv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        signal_cmp = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [3:0]  nzcv;
  logic        invalid;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fp_cmp_nzcv u0 (.clk, .rst_n, .in_valid, .fmt, .signal_cmp, .op_a, .op_b, .nzcv, .invalid);

  // {fmt, signal_cmp, a, b, exp_nzcv, exp_invalid}
  localparam int NV = 18;
  localparam logic [135:0] VEC [0:NV-1] = '{
    {2'd0, 1'b0, 64'h3C00, 64'h3C00, 4'b0110, 1'b0},                         // R1
    {2'd0, 1'b0, 64'h3C00, 64'h4000, 4'b1000, 1'b0},                         // R2
    {2'd0, 1'b0, 64'h4000, 64'h3C00, 4'b0010, 1'b0},                         // R3
    {2'd0, 1'b0, 64'h0000, 64'h8000, 4'b0110, 1'b0},                         // R6
    {2'd0, 1'b0, 64'hBC00, 64'hC000, 4'b0010, 1'b0},                         // R7
    {2'd0, 1'b0, 64'hC000, 64'hBC00, 4'b1000, 1'b0},                         // R7
    {2'd0, 1'b0, 64'hFC00, 64'h3C00, 4'b1000, 1'b0},                         // R8
    {2'd0, 1'b0, 64'h7E00, 64'h3C00, 4'b0011, 1'b0},                         // R4 R9
    {2'd0, 1'b0, 64'h3C00, 64'h7C01, 4'b0011, 1'b1},                         // R9
    {2'd0, 1'b1, 64'h7E00, 64'h3C00, 4'b0011, 1'b1},                         // R10
    {2'd1, 1'b0, 64'h3F800000, 64'h3FC00000, 4'b1000, 1'b0},                 // R2
    {2'd1, 1'b0, 64'h7F800000, 64'h7F7FFFFF, 4'b0010, 1'b0},                 // R8
    {2'd1, 1'b0, 64'hFFFFFFFF_3F800000, 64'h3F800000, 4'b0110, 1'b0},        // R5
    {2'd0, 1'b0, 64'h0000_0000_FFFF_3C00, 64'h3C00, 4'b0110, 1'b0},          // R5
    {2'd2, 1'b0, 64'h3FF0000000000000, 64'hBFF0000000000000, 4'b0010, 1'b0}, // R3
    {2'd2, 1'b0, 64'h7FF0000000000001, 64'h0, 4'b0011, 1'b1},                // R9
    {2'd3, 1'b0, 64'h4000000000000000, 64'h3FF0000000000000, 4'b0010, 1'b0}, // R5
    {2'd2, 1'b1, 64'h7FF0000000000000, 64'h7FF0000000000000, 4'b0110, 1'b0}  // R8 R10
  };

  task automatic check(input string req, input logic [3:0] en, input logic ei);
    n_chk++;
    if (nzcv !== en || invalid !== ei) begin
      n_bad++;
      $display("FAIL %s: nzcv=%b invalid=%b expected nzcv=%b invalid=%b", req, nzcv, invalid, en, ei);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic m, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    fmt = f; signal_cmp = m; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", 4'b0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][135:134], VEC[i][133], VEC[i][132:69], VEC[i][68:5]);
      check($sformatf("vector %0d (R1..R10)", i), VEC[i][4:1], VEC[i][0]);
    end

    // R11: inputs change without strobe, outputs hold
    apply(2'd0, 1'b0, 64'h3C00, 64'h4000);
    check("R2", 4'b1000, 1'b0);
    fmt = 2'd0; signal_cmp = 1'b1; op_a = 64'h7C01; op_b = 64'h0;
    repeat (3) @(negedge clk);
    check("R11 hold", 4'b1000, 1'b0);
    // R11: no combinational path, value before the capture edge is the old one
    in_valid = 1'b1;
    #1;
    check("R11 before edge", 4'b1000, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 after edge", 4'b0011, 1'b1);

    // R12: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 mid-run", 4'b0000, 1'b0);
    rst_n = 1'b1;
    apply(2'd1, 1'b1, 64'hBF800000, 64'h3F800000);
    check("R2 after reset", 4'b1000, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule